// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a load/store path. It holds sixteen entries. Each entry has a valid flag, a virtual page number, a physical page number and an 8-bit address-space identifier. A parameter arranges the sixteen entries as direct mapped, 2-way, 4-way or fully associative. Each entry carries the identifier of the process that owns it, so translations from several processes can sit in the buffer at the same time. A process switch therefore does not have to empty the buffer.

A lookup presents a virtual address and the current identifier, and gets back hit or miss and the physical address within the same cycle. After a miss, the walker outside the block installs the translation through the fill port. The installed entry is visible from the next cycle. When a set is full, a second parameter selects the victim: either the least-recently-used way or a way chosen by a free-running LFSR. A flush input invalidates every entry in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, resp_paddr[11:0] equals req_vaddr[11:0], and resp_paddr[31:12] is the physical page number stored with the matching entry.
- R2: resp_hit is 1 only when req_valid is 1 and a valid entry in the selected set holds both the presented virtual page number and the presented identifier. The same page under a different identifier misses.
- R3: On a miss, resp_hit is 0 and resp_paddr is all zeros.
- R4: After reset, every entry is invalid, so every lookup misses.
- R5: The set is the virtual page number modulo (16 / WAYS). A fill only ever replaces a way inside that set, and entries in other sets stay resident.
- R6: Lookup is combinational. A fill applied at a clock edge hits on the lookup in the cycle that follows.
- R7: A fill goes into the lowest-numbered invalid way of its set before any valid way is evicted.
- R8: With the LRU policy and a full set, the fill evicts the way whose last use lies furthest back. A use is a hit or a fill.
- R9: With the random policy and a full set, the fill evicts exactly one resident entry, and the new entry hits.
- R10: flush_all clears every valid flag, so all lookups in the next cycle miss.
- R11: When flush_all and fill_en are high in the same cycle, the flush wins and nothing is installed.
- R12: When a fill and a lookup hit occur in the same cycle, only the fill counts as a use for LRU ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Identifier of the running process |
| resp_hit | output | 1 | The lookup found a matching entry |
| resp_paddr | output | 32 | Translated physical address, zero on miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asid | input | 8 | Identifier to install |
| fill_ppn | input | 20 | Physical page number to install |
| flush_all | input | 1 | Invalidate every entry at the next edge |

## Verification
Damage to a valid flag or a tag shows up at the first lookup of that page. The lookup either misses when it should hit, or hits and returns a frame from another process. Because lookup is combinational, the error appears in the same cycle. A wrong LRU ranking stays hidden until its set fills up. It then shows as a miss on a recently used page, on the lookup right after the eviction. The bench compares every cycle against a timestamp model, so such a miss is reported on that cycle.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

   typedef enum logic {
      REPL_RANDOM = 1'b0,
      REPL_LRU    = 1'b1
   } repl_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [15:0] state
);

   logic [15:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= SEED;
      else        sr_q <= {sr_q[14:0], sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10]};
   end

   assign state = sr_q;

endmodule

// File: rtl/tlb_lru_ranks.sv
module tlb_lru_ranks #(
   parameter int WAYS = 4,
   parameter int RW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [RW-1:0] touch_way,
   output logic [RW-1:0] oldest_way
);

   // rank 0 = most recent, rank WAYS-1 = eviction candidate
   logic [RW-1:0] rank_q [WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) rank_q[w] <= RW'(w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (RW'(w) == touch_way)                rank_q[w] <= '0;
            else if (rank_q[w] < rank_q[touch_way]) rank_q[w] <= rank_q[w] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (rank_q[w] == RW'(WAYS - 1)) oldest_way = RW'(w);
   end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import asid_tlb_pkg::*;
#(
   parameter int    VA_W      = 32,
   parameter int    PA_W      = 32,
   parameter int    PAGE_BITS = 12,
   parameter int    ENTRIES   = 16,
   parameter int    WAYS      = 4,
   parameter int    ASID_W    = 8,
   parameter repl_e REPL      = REPL_LRU
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [VA_W-1:0]           req_vaddr,
   input  logic [ASID_W-1:0]         req_asid,
   output logic                      resp_hit,
   output logic [PA_W-1:0]           resp_paddr,
   input  logic                      fill_en,
   input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input  logic [ASID_W-1:0]         fill_asid,
   input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input  logic                      flush_all
);

   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int SETS  = ENTRIES / WAYS;
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   initial begin
      assert (is_pow2(WAYS) && WAYS <= ENTRIES && (ENTRIES % WAYS) == 0)
         else $error("asid_tlb: WAYS must be a power of two dividing ENTRIES");
      assert (PAGE_BITS > 0 && PAGE_BITS < VA_W && PAGE_BITS < PA_W)
         else $error("asid_tlb: PAGE_BITS out of range");
   end

   logic              ent_v_q    [ENTRIES];
   logic [VPN_W-1:0]  ent_vpn_q  [ENTRIES];
   logic [PPN_W-1:0]  ent_ppn_q  [ENTRIES];
   logic [ASID_W-1:0] ent_asid_q [ENTRIES];

   logic [VPN_W-1:0] req_vpn;
   logic [SET_W-1:0] req_set, fill_set;
   logic [WAYS-1:0]  hit_vec;
   logic [WAY_W-1:0] hit_way, free_way, policy_way, fill_way;
   logic [PPN_W-1:0] hit_ppn;
   logic             free_found, fill_go;

   assign req_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
   assign req_set  = SET_W'(req_vpn % VPN_W'(SETS));
   assign fill_set = SET_W'(fill_vpn % VPN_W'(SETS));
   assign fill_go  = fill_en && !flush_all;

   // lookup: search only the ways of the selected set
   always_comb begin
      hit_vec = '0;
      hit_way = '0;
      hit_ppn = '0;
      for (int w = 0; w < WAYS; w++) begin
         automatic int e = int'(req_set) * WAYS + w;
         if (ent_v_q[e] && ent_vpn_q[e] == req_vpn && ent_asid_q[e] == req_asid) begin
            hit_vec[w] = 1'b1;
            hit_way    = WAY_W'(w);
            hit_ppn    = ent_ppn_q[e];
         end
      end
   end

   assign resp_hit   = req_valid && (|hit_vec);
   assign resp_paddr = resp_hit ? {hit_ppn, req_vaddr[PAGE_BITS-1:0]} : '0;

   // victim: lowest invalid way, else the policy's choice
   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!ent_v_q[int'(fill_set) * WAYS + w]) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
      fill_way = free_found ? free_way : policy_way;
   end

   generate
      if (REPL == REPL_LRU) begin : g_lru
         logic [WAY_W-1:0] oldest [SETS];
         for (genvar s = 0; s < SETS; s++) begin : g_set
            logic             touch_s;
            logic [WAY_W-1:0] touch_w;
            assign touch_s = fill_go ? (fill_set == SET_W'(s))
                                     : (resp_hit && req_set == SET_W'(s));
            assign touch_w = fill_go ? fill_way : hit_way;
            tlb_lru_ranks #(.WAYS(WAYS), .RW(WAY_W)) u_ranks (
               .clk        (clk),
               .rst_n      (rst_n),
               .touch      (touch_s),
               .touch_way  (touch_w),
               .oldest_way (oldest[s])
            );
         end
         assign policy_way = oldest[fill_set];
      end else begin : g_rnd
         logic [15:0] lfsr_state;
         tlb_lfsr u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .state (lfsr_state)
         );
         assign policy_way = WAY_W'(lfsr_state % 16'(WAYS));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) ent_v_q[e] <= 1'b0;
      end else if (flush_all) begin
         for (int e = 0; e < ENTRIES; e++) ent_v_q[e] <= 1'b0;
      end else if (fill_en) begin
         ent_v_q[int'(fill_set) * WAYS + int'(fill_way)] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         ent_vpn_q [int'(fill_set) * WAYS + int'(fill_way)] <= fill_vpn;
         ent_ppn_q [int'(fill_set) * WAYS + int'(fill_way)] <= fill_ppn;
         ent_asid_q[int'(fill_set) * WAYS + int'(fill_way)] <= fill_asid;
      end
   end

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ASID_W    = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic [VA_W-1:0]           req_vaddr,
   input logic [ASID_W-1:0]         req_asid,
   input logic                      resp_hit,
   input logic [PA_W-1:0]           resp_paddr,
   input logic                      fill_en,
   input logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input logic [ASID_W-1:0]         fill_asid,
   input logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input logic                      flush_all
);

   assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> resp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]);

   assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> req_valid);

   assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_hit |-> resp_paddr == '0);

   assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush_all) |=>
         (!(req_valid && req_vaddr[VA_W-1:PAGE_BITS] == $past(fill_vpn)
            && req_asid == $past(fill_asid))
          || (resp_hit && resp_paddr[PA_W-1:PAGE_BITS] == $past(fill_ppn))));

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !resp_hit);

endmodule

bind asid_tlb tlb_checker #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ASID_W(ASID_W)
) u_chk (.*);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

   localparam int TW    = 4;
   localparam int TSETS = 16 / TW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req_valid, fill_en, flush_all, resp_hit;
   logic [31:0] req_vaddr, resp_paddr;
   logic [7:0]  req_asid, fill_asid;
   logic [19:0] fill_vpn, fill_ppn;

   logic        r_req_valid, r_fill_en, r_resp_hit;
   logic [31:0] r_req_vaddr, r_resp_paddr;
   logic [7:0]  r_req_asid, r_fill_asid;
   logic [19:0] r_fill_vpn, r_fill_ppn;

   asid_tlb #(.WAYS(TW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_asid(req_asid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_ppn(fill_ppn), .flush_all(flush_all));

   asid_tlb #(.WAYS(16), .REPL(asid_tlb_pkg::REPL_RANDOM)) uut_rnd (
      .clk(clk), .rst_n(rst_n), .req_valid(r_req_valid), .req_vaddr(r_req_vaddr),
      .req_asid(r_req_asid), .resp_hit(r_resp_hit), .resp_paddr(r_resp_paddr),
      .fill_en(r_fill_en), .fill_vpn(r_fill_vpn), .fill_asid(r_fill_asid),
      .fill_ppn(r_fill_ppn), .flush_all(1'b0));

   int checks = 0;
   int errors = 0;

   // behavioural reference: flat entry list with last-use timestamps
   bit          mv   [16];
   logic [19:0] mvpn [16];
   logic [19:0] mppn [16];
   logic [7:0]  masid[16];
   int          mts  [16];
   int          now = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act_pa,
                        input bit act_h, input logic [31:0] exp_pa, input bit exp_h);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h",
                  tag, act_h, act_pa, exp_h, exp_pa);
      end
   endtask

   task automatic step(input bit rq, input logic [31:0] va, input logic [7:0] asid,
                       input bit fe, input logic [19:0] fvpn, input logic [7:0] fasid,
                       input logic [19:0] fppn, input bit fl, input string tag);
      bit          ehit;
      logic [31:0] epa;
      int          he, s, pick, e;
      @(negedge clk);
      req_valid = rq; req_vaddr = va; req_asid = asid;
      fill_en = fe; fill_vpn = fvpn; fill_asid = fasid; fill_ppn = fppn; flush_all = fl;
      #1;
      ehit = 0; epa = '0; he = -1;
      s = int'(va[31:12]) % TSETS;
      if (rq) begin
         for (int w = 0; w < TW; w++) begin
            e = s * TW + w;
            if (mv[e] && mvpn[e] == va[31:12] && masid[e] == asid) begin
               ehit = 1; epa = {mppn[e], va[11:0]}; he = e;
            end
         end
      end
      check(resp_hit == ehit && resp_paddr == epa, tag, resp_paddr, resp_hit, epa, ehit);
      now++;
      if (fl) begin
         for (int i = 0; i < 16; i++) mv[i] = 0;
      end else if (fe) begin
         s = int'(fvpn) % TSETS;
         pick = -1;
         for (int w = 0; w < TW; w++)
            if (!mv[s * TW + w] && pick < 0) pick = s * TW + w;
         if (pick < 0) begin
            pick = s * TW;
            for (int w = 1; w < TW; w++)
               if (mts[s * TW + w] < mts[pick]) pick = s * TW + w;
         end
         mv[pick] = 1; mvpn[pick] = fvpn; mppn[pick] = fppn; masid[pick] = fasid;
         mts[pick] = now;
      end else if (ehit) begin
         mts[he] = now;
      end
   endtask

   task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                       input logic [7:0] asid, input string tag);
      step(1, {vpn, off}, asid, 0, '0, '0, '0, 0, tag);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                       input logic [19:0] ppn, input string tag);
      step(0, '0, '0, 1, vpn, asid, ppn, 0, tag);
   endtask

   initial begin : watchdog
      #(4 * 50000);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int hits;
      req_valid = 0; req_vaddr = '0; req_asid = '0; fill_en = 0; fill_vpn = '0;
      fill_asid = '0; fill_ppn = '0; flush_all = 0;
      r_req_valid = 0; r_req_vaddr = '0; r_req_asid = '0; r_fill_en = 0;
      r_fill_vpn = '0; r_fill_asid = '0; r_fill_ppn = '0;
      for (int i = 0; i < 16; i++) begin mv[i] = 0; mts[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state
      look(20'd30, 12'h444, 8'd11, "R4 empty after reset");
      look(20'd0, 12'h000, 8'd0, "R4 empty after reset zero page");

      // R6, R1, R2, R3
      fill(20'd30, 8'd11, 20'h000a6, "R6 fill");
      look(20'd30, 12'h444, 8'd11, "R6 R1 hit next cycle");
      look(20'd30, 12'hfff, 8'd11, "R1 offset passthrough");
      look(20'd30, 12'h444, 8'd12, "R2 other asid misses");
      step(0, {20'd30, 12'h010}, 8'd11, 0, '0, '0, '0, 0, "R2 no req no hit");
      look(20'd31, 12'h000, 8'd11, "R3 miss returns zero");

      // R7: fill set 2 through invalid ways
      fill(20'd46, 8'd11, 20'h000be, "R7 fill");
      fill(20'd6,  8'd11, 20'h000f1, "R7 fill");
      fill(20'd10, 8'd11, 20'h00021, "R7 fill");
      look(20'd46, 12'h008, 8'd11, "R7 second way resident");
      look(20'd10, 12'h008, 8'd11, "R7 fourth way resident");

      // R8: LRU eviction after a touch of the oldest
      look(20'd30, 12'h000, 8'd11, "R8 touch");
      look(20'd6, 12'h000, 8'd11, "R8 touch");
      look(20'd10, 12'h000, 8'd11, "R8 touch");
      fill(20'd14, 8'd11, 20'h00038, "R8 fill evicts 46");
      look(20'd46, 12'h000, 8'd11, "R8 lru way gone");
      look(20'd30, 12'h000, 8'd11, "R8 recent way kept");
      look(20'd14, 12'h000, 8'd11, "R8 new entry hits");

      // R12: same-cycle hit does not count when a fill happens
      step(1, {20'd6, 12'h0}, 8'd11, 1, 20'd3, 8'd11, 20'h00077, 0, "R12 hit with fill");
      fill(20'd18, 8'd11, 20'h00055, "R12 fill evicts 6");
      look(20'd6, 12'h000, 8'd11, "R12 dropped touch evicted");
      look(20'd18, 12'h000, 8'd11, "R12 new entry hits");

      // R5: other sets unaffected
      look(20'd3, 12'h123, 8'd11, "R5 set 3 kept");
      fill(20'd30, 8'd12, 20'h00099, "R5 R2 second asid");
      look(20'd30, 12'h000, 8'd12, "R2 asid 12 translation");
      look(20'd3, 12'h000, 8'd11, "R5 set 3 still kept");

      // first access misses, later ones hit
      for (int p = 0; p < 4; p++) begin
         look(20'h00040 + p, 12'h000, 8'd7, "R4 R6 first access");
         fill(20'h00040 + p, 8'd7, 20'h00200 + p, "R6 fill stream");
         for (int k = 1; k < 4; k++)
            look(20'h00040 + p, 12'(k * 4), 8'd7, "R6 R1 stream hit");
      end

      // R11: flush beats fill
      step(0, '0, '0, 1, 20'h00100, 8'd11, 20'h00001, 1, "R11 fill with flush");
      look(20'h00100, 12'h000, 8'd11, "R11 fill dropped");
      look(20'd3, 12'h000, 8'd11, "R11 R10 flushed");

      // R10: flush alone
      fill(20'd5, 8'd1, 20'h00abc, "R10 fill");
      look(20'd5, 12'h000, 8'd1, "R10 resident");
      step(0, '0, '0, 0, '0, '0, '0, 1, "R10 flush");
      look(20'd5, 12'h000, 8'd1, "R10 miss after flush");

      // R9: random policy on a fully associative instance
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         r_fill_en = 1; r_fill_vpn = 20'h00200 + i; r_fill_asid = 8'd5; r_fill_ppn = 20'(i);
      end
      @(negedge clk); r_fill_en = 0;
      hits = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         r_req_valid = 1; r_req_vaddr = {20'h00200 + i, 12'h000}; r_req_asid = 8'd5;
         #1; if (r_resp_hit && r_resp_paddr[31:12] == 20'(i)) hits++;
      end
      r_req_valid = 0;
      checks++;
      if (hits != 16) begin
         errors++; $display("FAIL R7 random fill: hits=%0d expected 16", hits);
      end
      @(negedge clk);
      r_fill_en = 1; r_fill_vpn = 20'h00300; r_fill_asid = 8'd5; r_fill_ppn = 20'h00777;
      @(negedge clk); r_fill_en = 0;
      r_req_valid = 1; r_req_vaddr = {20'h00300, 12'h000}; #1;
      checks++;
      if (!(r_resp_hit && r_resp_paddr == 32'h00777000)) begin
         errors++;
         $display("FAIL R9 new entry: hit=%0b pa=%h expected hit=1 pa=00777000",
                  r_resp_hit, r_resp_paddr);
      end
      hits = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         r_req_vaddr = {20'h00200 + i, 12'h000}; #1;
         if (r_resp_hit) hits++;
      end
      r_req_valid = 0;
      checks++;
      if (hits != 15) begin
         errors++; $display("FAIL R9 one evicted: hits=%0d expected 15", hits);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule